// File: doc/BRIEF.md
# Answer-to-Reset Sequence Parser

This block follows the byte stream a contact card sends after reset and works out its structure as it arrives. The first byte is handed over raw, exactly as the receiver assembled it from the line with the earliest bit in bit 0. The block recognises the initial character from it and reports the coding convention. The byte receiver upstream uses that result, so every later byte arrives already decoded. The block then reads the format character. Its presence bitmap and its count of historical bytes tell the block which interface characters and how many historical bytes come next.

Interface characters are taken in a fixed order within each level. A protocol-announcing character opens a further level through its own presence bitmap. Three first-level values are captured: the protocol number, the extra guard time and the programming-voltage byte. Each of them is zero when its character is absent. A trailing check byte is expected only when a protocol other than type 0 was announced. When the last expected byte has arrived, the block raises a done flag and ignores further bytes until a restart. A malformed initial character, or too long a sequence, raises an error flag instead.

A pulse on `start_i` prepares the block for a new card session. Bit timing, parity and the meaning of the historical bytes are handled elsewhere.

Top module: `atr_parser`

## Requirements
- R1: The first byte after restart is the raw initial character. Raw 0x3B selects the direct convention (`inverse_o`=0). Raw 0x03 selects the inverse convention (`inverse_o`=1). Either value is counted in `len_o`.
- R2: Any other first byte sets `err_o` in the following cycle and is not counted. After that, no byte changes any output until restart.
- R3: The byte after the initial character is the format character. Bits 4, 5, 6 and 7 announce the A, B, C and D interface characters of level 1, in that order of arrival. Bits 3:0 give the number of historical bytes (0 to 15). The historical bytes follow the last interface character.
- R4: The level-1 B character sets `prog_volt_o` to its bits 4:0 and `prog_curr_o` to its bits 6:5. Both outputs are 0 when that character is absent.
- R5: The level-1 C character is presented on `guard_o`. The value is 0 when that character is absent.
- R6: Bits 3:0 of the level-1 D character are presented on `proto_o`, which is 0 when that character is absent. Bits 7:4 of any D character announce the A to D characters of the next level. Characters of level 2 and higher do not change `proto_o`, `guard_o` or the programming outputs.
- R7: One extra check byte is expected after the historical bytes if, and only if, some D character carried a nonzero protocol nibble.
- R8: `done_o` rises in the cycle after the last expected byte. `len_o` counts the accepted bytes, including the initial character. Bytes offered while `done_o` is high change no output.
- R9: A byte offered when 32 bytes have already followed the initial character, and the sequence is still not complete, sets `err_o`. `len_o` never exceeds 33.
- R10: After reset, and in the cycle after a `start_i` pulse, `len_o`, `done_o`, `err_o`, `inverse_o`, `proto_o`, `guard_o`, `prog_volt_o` and `prog_curr_o` are all 0. A byte offered in the same cycle as `start_i` is ignored.
- R11: `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous restart for a new sequence |
| byte_valid_i | input | 1 | Strobe: `byte_i` holds the next byte |
| byte_i | input | 8 | Received byte; raw for the first, decoded afterwards |
| inverse_o | output | 1 | Inverse coding convention detected |
| proto_o | output | 4 | First announced protocol type |
| guard_o | output | 8 | Extra guard time value |
| prog_volt_o | output | 5 | Programming-voltage field |
| prog_curr_o | output | 2 | Programming-current field |
| len_o | output | 6 | Bytes accepted, including the initial character |
| done_o | output | 1 | Whole sequence received |
| err_o | output | 1 | Malformed or over-long sequence |

## Verification
The assertions watch four things on every cycle:
- the length bound;
- that done and error are never high together;
- that a rejected initial character leads straight to the error state;
- that outputs stay frozen once the sequence is complete, and are cleared after a restart.

The choice of which byte counts as which character is only visible through scenarios. This covers presence bitmaps across levels, historical-byte counting, the conditional check byte, the defaults for absent characters and the 19-byte example with a format character of 0xBE. The bench drives these byte streams and compares the captured parameters and the completion point against values worked out by hand.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [2:0] {
    PH_TS, PH_T0, PH_IFC, PH_HIST, PH_TCK, PH_DONE, PH_ERR
  } phase_e;

  typedef enum logic [2:0] {
    CK_TS, CK_T0, CK_TA, CK_TB, CK_TC, CK_TD, CK_HIST, CK_TCK
  } kind_e;

  localparam logic [7:0] TS_RAW_DIRECT  = 8'h3B;
  localparam logic [7:0] TS_RAW_INVERSE = 8'h03;
endpackage

// File: rtl/atr_conv_detect.sv
module atr_conv_detect
  import atr_pkg::*;
(
  input  logic [7:0] raw_i,
  output logic       ok_o,
  output logic       inverse_o
);
  always_comb begin
    ok_o      = (raw_i == TS_RAW_DIRECT) || (raw_i == TS_RAW_INVERSE);
    inverse_o = (raw_i == TS_RAW_INVERSE);
  end
endmodule

// File: rtl/atr_walker.sv
module atr_walker
  import atr_pkg::*;
#(
  parameter int MAX_FOLLOW = 32,
  parameter int LEN_W      = $clog2(MAX_FOLLOW + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  input  logic             ts_ok_i,
  input  logic             ts_inv_i,
  output logic             cap_en_o,
  output kind_e            kind_o,
  output logic             lvl1_o,
  output logic [LEN_W-1:0] len_o,
  output logic             inverse_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_FOLLOW + 1);

  phase_e           phase_q, phase_n;
  logic [3:0]       pmap_q, pmap_n;
  logic [3:0]       hist_q, hist_n;
  logic             tck_q, tck_n;
  logic             lvl1_q, lvl1_n;
  logic             inv_q, inv_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             take, at_limit;

  function automatic phase_e pick_next(logic [3:0] pm, logic [3:0] hc, logic tk);
    if (pm != 4'd0)      return PH_IFC;
    else if (hc != 4'd0) return PH_HIST;
    else if (tk)         return PH_TCK;
    else                 return PH_DONE;
  endfunction

  always_comb begin
    unique case (phase_q)
      PH_TS:   kind_o = CK_TS;
      PH_T0:   kind_o = CK_T0;
      PH_IFC:  kind_o = pmap_q[0] ? CK_TA :
                        pmap_q[1] ? CK_TB :
                        pmap_q[2] ? CK_TC : CK_TD;
      PH_HIST: kind_o = CK_HIST;
      default: kind_o = CK_TCK;
    endcase
  end

  assign take     = valid_i && !start_i && (phase_q != PH_DONE) && (phase_q != PH_ERR);
  assign at_limit = (len_q == LEN_LIMIT);
  assign cap_en_o = take && !at_limit && (phase_q == PH_IFC);
  assign lvl1_o   = lvl1_q;

  always_comb begin
    phase_n = phase_q;
    pmap_n  = pmap_q;
    hist_n  = hist_q;
    tck_n   = tck_q;
    lvl1_n  = lvl1_q;
    inv_n   = inv_q;
    len_n   = len_q;
    if (start_i) begin
      phase_n = PH_TS;
      pmap_n  = '0;
      hist_n  = '0;
      tck_n   = 1'b0;
      lvl1_n  = 1'b1;
      inv_n   = 1'b0;
      len_n   = '0;
    end else if (take) begin
      if (at_limit) begin
        phase_n = PH_ERR;
      end else begin
        len_n = len_q + 1'b1;
        unique case (phase_q)
          PH_TS: begin
            if (ts_ok_i) begin
              inv_n   = ts_inv_i;
              phase_n = PH_T0;
            end else begin
              len_n   = len_q;
              phase_n = PH_ERR;
            end
          end
          PH_T0: begin
            pmap_n  = byte_i[7:4];
            hist_n  = byte_i[3:0];
            phase_n = pick_next(byte_i[7:4], byte_i[3:0], tck_q);
          end
          PH_IFC: begin
            if (kind_o == CK_TD) begin
              pmap_n = byte_i[7:4];
              lvl1_n = 1'b0;
              tck_n  = tck_q | (byte_i[3:0] != 4'd0);
            end else begin
              pmap_n = pmap_q & (pmap_q - 4'd1);
            end
            phase_n = pick_next(pmap_n, hist_q, tck_n);
          end
          PH_HIST: begin
            hist_n  = hist_q - 4'd1;
            phase_n = pick_next(pmap_q, hist_n, tck_q);
          end
          default: phase_n = PH_DONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_TS;
      pmap_q  <= '0;
      hist_q  <= '0;
      tck_q   <= 1'b0;
      lvl1_q  <= 1'b1;
      inv_q   <= 1'b0;
      len_q   <= '0;
    end else begin
      phase_q <= phase_n;
      pmap_q  <= pmap_n;
      hist_q  <= hist_n;
      tck_q   <= tck_n;
      lvl1_q  <= lvl1_n;
      inv_q   <= inv_n;
      len_q   <= len_n;
    end
  end

  assign len_o     = len_q;
  assign inverse_o = inv_q;
  assign done_o    = (phase_q == PH_DONE);
  assign err_o     = (phase_q == PH_ERR);

  // R9
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_LIMIT);

  // R2
  bad_ts_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TS && valid_i && !start_i && !ts_ok_i) |=> err_o);
endmodule

// File: rtl/atr_param_capture.sv
module atr_param_capture
  import atr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cap_en_i,
  input  kind_e      kind_i,
  input  logic       lvl1_i,
  input  logic [7:0] byte_i,
  output logic [3:0] proto_o,
  output logic [7:0] guard_o,
  output logic [7:0] prog_o
);
  logic [3:0] proto_q;
  logic [7:0] guard_q, prog_q;
  logic       hit1;

  assign hit1 = cap_en_i && lvl1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      proto_q <= '0;
      guard_q <= '0;
      prog_q  <= '0;
    end else if (start_i) begin
      proto_q <= '0;
      guard_q <= '0;
      prog_q  <= '0;
    end else if (hit1) begin
      if (kind_i == CK_TB) prog_q  <= byte_i;
      if (kind_i == CK_TC) guard_q <= byte_i;
      if (kind_i == CK_TD) proto_q <= byte_i[3:0];
    end
  end

  assign proto_o = proto_q;
  assign guard_o = guard_q;
  assign prog_o  = prog_q;

  // R6
  upper_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl1_i && !start_i) |=> ($stable(proto_q) && $stable(guard_q) && $stable(prog_q)));
endmodule

// File: rtl/atr_parser.sv
module atr_parser
  import atr_pkg::*;
#(
  parameter int MAX_FOLLOW = 32,
  localparam int LEN_W     = $clog2(MAX_FOLLOW + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             inverse_o,
  output logic [3:0]       proto_o,
  output logic [7:0]       guard_o,
  output logic [4:0]       prog_volt_o,
  output logic [1:0]       prog_curr_o,
  output logic [LEN_W-1:0] len_o,
  output logic             done_o,
  output logic             err_o
);
  logic       ts_ok, ts_inv, cap_en, lvl1;
  kind_e      kind;
  logic [7:0] prog;

  atr_conv_detect u_conv (
    .raw_i     (byte_i),
    .ok_o      (ts_ok),
    .inverse_o (ts_inv)
  );

  atr_walker #(.MAX_FOLLOW(MAX_FOLLOW), .LEN_W(LEN_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .valid_i   (byte_valid_i),
    .byte_i    (byte_i),
    .ts_ok_i   (ts_ok),
    .ts_inv_i  (ts_inv),
    .cap_en_o  (cap_en),
    .kind_o    (kind),
    .lvl1_o    (lvl1),
    .len_o     (len_o),
    .inverse_o (inverse_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  atr_param_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cap_en_i (cap_en),
    .kind_i   (kind),
    .lvl1_i   (lvl1),
    .byte_i   (byte_i),
    .proto_o  (proto_o),
    .guard_o  (guard_o),
    .prog_o   (prog)
  );

  assign prog_volt_o = prog[4:0];
  assign prog_curr_o = prog[6:5];

  // R11
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R8
  frozen_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(len_o) && $stable(proto_o) &&
                              $stable(guard_o) && $stable(prog_volt_o)));

  // R10
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (len_o == '0 && !done_o && !err_o && !inverse_o &&
                 proto_o == 4'd0 && guard_o == 8'd0 && prog_volt_o == 5'd0));
endmodule

// File: tb/tb_atr_parser.sv
`timescale 1ns/1ps
module tb_atr_parser;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic       bvalid = 1'b0;
  logic [7:0] bdata = 8'h00;
  logic       inverse, done, err;
  logic [3:0] proto;
  logic [7:0] guard;
  logic [4:0] pvolt;
  logic [1:0] pcurr;
  logic [5:0] len;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  atr_parser dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .byte_valid_i(bvalid),
    .byte_i(bdata), .inverse_o(inverse), .proto_o(proto), .guard_o(guard),
    .prog_volt_o(pvolt), .prog_curr_o(pcurr), .len_o(len), .done_o(done),
    .err_o(err)
  );

  typedef struct packed {
    logic [3:0]       n;
    logic [0:11][7:0] b;
    logic             done;
    logic             err;
    logic             inv;
    logic [3:0]       proto;
    logic [7:0]       guard;
    logic [7:0]       prog;
    logic [5:0]       len;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [0:NV-1] = '{
    '{4'd2, {8'h3B, 8'h00, 80'h0},                          1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 6'd2},
    '{4'd2, {8'h03, 8'h00, 80'h0},                          1'b1, 1'b0, 1'b1, 4'd0, 8'h00, 8'h00, 6'd2},
    '{4'd4, {8'h3B, 8'h60, 8'h00, 8'h05, 64'h0},            1'b1, 1'b0, 1'b0, 4'd0, 8'h05, 8'h00, 6'd4},
    '{4'd7, {8'h3B, 8'h81, 8'h31, 8'h11, 8'h22, 8'hAA, 8'h5A, 40'h0}, 1'b1, 1'b0, 1'b0, 4'd1, 8'h00, 8'h00, 6'd7},
    '{4'd6, {8'h3B, 8'h81, 8'h31, 8'h11, 8'h22, 8'hAA, 48'h0}, 1'b0, 1'b0, 1'b0, 4'd1, 8'h00, 8'h00, 6'd6},
    '{4'd4, {8'h3B, 8'h21, 8'h65, 8'h11, 64'h0},            1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 8'h65, 6'd4},
    '{4'd2, {8'h3F, 8'h00, 80'h0},                          1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00, 6'd0},
    '{4'd3, {8'h3B, 8'h80, 8'h00, 72'h0},                   1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 6'd3},
    '{4'd3, {8'h3B, 8'h02, 8'h41, 72'h0},                   1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 6'd3},
    '{4'd3, {8'h3B, 8'h40, 8'hFF, 72'h0},                   1'b1, 1'b0, 1'b0, 4'd0, 8'hFF, 8'h00, 6'd3},
    '{4'd3, {8'h3B, 8'h00, 8'h55, 72'h0},                   1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00, 6'd2},
    '{4'd3, {8'h03, 8'h40, 8'h0C, 72'h0},                   1'b1, 1'b0, 1'b1, 4'd0, 8'h0C, 8'h00, 6'd3},
    '{4'd5, {8'h3B, 8'h80, 8'h41, 8'h09, 8'h77, 56'h0},     1'b1, 1'b0, 1'b0, 4'd1, 8'h00, 8'h00, 6'd5}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    bvalid = 1'b1;
    bdata  = b;
    @(negedge clk);
    bvalid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_all(string tag, vec_t v);
    check({tag, " R8 done"}, 32'(done), 32'(v.done));
    check({tag, " R2 R9 err"}, 32'(err), 32'(v.err));
    check({tag, " R1 inverse"}, 32'(inverse), 32'(v.inv));
    check({tag, " R6 proto"}, 32'(proto), 32'(v.proto));
    check({tag, " R5 guard"}, 32'(guard), 32'(v.guard));
    check({tag, " R4 volt"}, 32'(pvolt), 32'(v.prog[4:0]));
    check({tag, " R4 curr"}, 32'(pcurr), 32'(v.prog[6:5]));
    check({tag, " R3 R8 len"}, 32'(len), 32'(v.len));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset len", 32'(len), 0);
    check("R10 reset done", 32'(done), 0);
    check("R10 reset err", 32'(err), 0);
    check("R10 reset proto", 32'(proto), 0);
    check("R10 reset inverse", 32'(inverse), 0);

    for (int i = 0; i < NV; i++) begin
      restart();
      for (int k = 0; k < int'(VT[i].n); k++) send(VT[i].b[k]);
      check_all($sformatf("vec%0d", i), VT[i]);
    end

    // R3 example: format 0xBE, A1 B1 D1 plus 14 historical bytes, 19 total
    restart();
    send(8'h3B); send(8'hBE); send(8'h11); send(8'h00); send(8'h00);
    for (int k = 0; k < 13; k++) send(8'(8'h40 + k));
    check("R3 one short done", 32'(done), 0);
    send(8'h4D);
    check("R3 full done", 32'(done), 1);
    check("R3 full len", 32'(len), 19);
    check("R7 no check byte proto", 32'(proto), 0);

    // R9 over-long chain of D characters
    restart();
    send(8'h3B); send(8'h80);
    for (int k = 0; k < 31; k++) send(8'h81);
    check("R9 at limit err", 32'(err), 0);
    check("R9 at limit len", 32'(len), 33);
    send(8'h81);
    check("R9 over limit err", 32'(err), 1);
    check("R11 no done with err", 32'(done), 0);

    // R2 bytes after a bad initial character change nothing
    restart();
    send(8'h3A); send(8'h40); send(8'h12);
    check("R2 err", 32'(err), 1);
    check("R2 guard untouched", 32'(guard), 0);
    check("R2 len", 32'(len), 0);

    // R10 restart mid-stream, byte alongside start ignored
    restart();
    send(8'h3B); send(8'h60); send(8'h25);
    @(negedge clk);
    start = 1'b1; bvalid = 1'b1; bdata = 8'h3B;
    @(negedge clk);
    start = 1'b0; bvalid = 1'b0;
    check("R10 restart len", 32'(len), 0);
    check("R10 restart prog", 32'(pvolt), 0);
    send(8'h3B); send(8'h40); send(8'h07);
    check("R5 after restart guard", 32'(guard), 7);
    check("R8 after restart done", 32'(done), 1);
    restart();
    check("R10 clear after done guard", 32'(guard), 0);
    check("R10 clear after done", 32'(done), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule